// File: doc/BRIEF.md
# XOR-Encoded Multiport Memory

This block is a memory with several write ports and several read ports that all work in the same cycle. It is built only from single-write, single-read storage copies and XOR logic. No table records which port wrote an address last. Each write port owns a group of storage copies. That group holds the port's data XORed with whatever the other groups hold at the same address. A read XORs together what every group holds at its address, and the result is the most recent value written there.

A write takes two internal cycles, because the copies read synchronously. In the first cycle the port looks up the target address in every other group. In the second cycle it stores the encoded word into all copies of its own group. Each copy passes a word being written straight to its read output when the addresses match. Because of this, lookups and reads that follow a write in the next cycle see the new word. The caller must never make two write ports target the same address in one cycle.

Top module: `xmp_xor_mem`

## Requirements
- R1: An asynchronous reset (active-low `rst_ni`, released on the clock) clears every location, so every read port returns zero after reset. This also holds for a reset applied in the middle of operation.
- R2: A write issued in cycle t on port p (`wr_en_i[p]`=1, address `wr_addr_i[p*AW +: AW]`, data `wr_data_i[p*DW +: DW]`) is returned by any read port whose read of that address is issued in cycle t+1 or later.
- R3: The data for the address on `rd_addr_i[r*AW +: AW]` appears on `rd_data_o[r*DW +: DW]` one cycle after the address is presented. While the address is held and nothing is written, the data stays unchanged.
- R4: A read issued in the same cycle as a write to the same address returns the contents from before that write.
- R5: Writes to one address in adjacent cycles, from different ports, leave the later write's data in place.
- R6: Each read port works independently. Several read ports may read the same address or different addresses in one cycle.
- R7: All write ports may write in the same cycle, provided their addresses differ. Two ports writing the same address in one cycle is not allowed.
- R8: When `wr_en_i[p]` is 0, the address and data on port p are ignored and no location changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | NWR | Write enable, bit p for write port p |
| wr_addr_i | input | NWR*AW | Write addresses, port p in bits p*AW +: AW |
| wr_data_i | input | NWR*DW | Write data, port p in bits p*DW +: DW |
| rd_addr_i | input | NRD*AW | Read addresses, port r in bits r*AW +: AW |
| rd_data_o | output | NRD*DW | Read data, port r in bits r*DW +: DW, one cycle after the address |

## Verification
The bench targets these corner cases:
- **Two ports writing one address in adjacent cycles.** This needs the lookup copy to capture the word being written in that same cycle. A design that drops this pass-through stores a word encoded against stale contents, and reads return garbage rather than either written value.
- **A read in the same cycle as a write to its address.** Here a design with the wrong write order returns the new data one cycle too early.
- **Disabled ports carrying live addresses and data.** These expose a design that does not gate its stage register on the write enable.
- **The first and last addresses, and reset in mid-run.** Random traffic over a narrow address range then compares every read with a plain array model.

// File: rtl/xmp_pkg.sv
package xmp_pkg;

  // storage copies owned by one write port: lookups for peers plus read ports
  function automatic int copies_per_group(input int nwr, input int nrd);
    return nwr - 1 + nrd;
  endfunction

  // lookup slot in group 'owner' that serves write port 'requester'
  function automatic int slot_of(input int owner, input int requester);
    return (requester < owner) ? requester : requester - 1;
  endfunction

  // write port served by lookup slot 'slot' of group 'owner'
  function automatic int port_of(input int owner, input int slot);
    return (slot < owner) ? slot : slot + 1;
  endfunction

endpackage

// File: rtl/xmp_rst_sync.sv
module xmp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/xmp_bank.sv
module xmp_bank #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rd_d;

  // word being written in this cycle passes straight to the read register
  always_comb begin
    if (wr_en && (wr_addr == rd_addr)) begin
      rd_d = wr_data;
    end else begin
      rd_d = mem_q[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        mem_q[i] <= '0;
      end
      rd_data <= '0;
    end else begin
      if (wr_en) begin
        mem_q[wr_addr] <= wr_data;
      end
      rd_data <= rd_d;
    end
  end

  AST_BANK_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == rd_addr)) |=> (rd_data == $past(wr_data)))
    else $error("bank pass-through lost");  // R5

  AST_BANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(rd_addr)) |=> $stable(rd_data))
    else $error("bank read drifted");  // R3

endmodule

// File: rtl/xmp_group.sv
module xmp_group #(
  parameter int NWR   = 2,
  parameter int NRD   = 2,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int NLK  = NWR - 1,
  localparam int NCP  = xmp_pkg::copies_per_group(NWR, NRD)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] lk_addr   [NLK],
  input  logic [DW-1:0] peer_data [NLK],
  input  logic [AW-1:0] rd_addr   [NRD],
  output logic [DW-1:0] lk_data   [NLK],
  output logic [DW-1:0] rd_data   [NRD]
);

  // stage two of the write: held address and data
  logic          st_vld_q, st_vld_d;
  logic [AW-1:0] st_addr_q, st_addr_d;
  logic [DW-1:0] st_data_q, st_data_d;
  logic [DW-1:0] enc_word;

  always_comb begin
    st_vld_d  = wr_en;
    st_addr_d = st_addr_q;
    st_data_d = st_data_q;
    if (wr_en) begin
      st_addr_d = wr_addr;
      st_data_d = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_vld_q  <= 1'b0;
      st_addr_q <= '0;
      st_data_q <= '0;
    end else begin
      st_vld_q  <= st_vld_d;
      st_addr_q <= st_addr_d;
      st_data_q <= st_data_d;
    end
  end

  // new data folded with what every other group holds at this address
  always_comb begin
    enc_word = st_data_q;
    for (int k = 0; k < NLK; k++) begin
      enc_word = enc_word ^ peer_data[k];
    end
  end

  for (genvar c = 0; c < NCP; c++) begin : g_copy
    if (c < NLK) begin : g_lookup
      xmp_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_vld_q),
        .wr_addr (st_addr_q),
        .wr_data (enc_word),
        .rd_addr (lk_addr[c]),
        .rd_data (lk_data[c])
      );
    end else begin : g_read
      xmp_bank #(.DW(DW), .DEPTH(DEPTH)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (st_vld_q),
        .wr_addr (st_addr_q),
        .wr_data (enc_word),
        .rd_addr (rd_addr[c-NLK]),
        .rd_data (rd_data[c-NLK])
      );
    end
  end

endmodule

// File: rtl/xmp_xor_mem.sv
module xmp_xor_mem #(
  parameter int NWR   = 2,
  parameter int NRD   = 2,
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NWR-1:0]    wr_en_i,
  input  logic [NWR*AW-1:0] wr_addr_i,
  input  logic [NWR*DW-1:0] wr_data_i,
  input  logic [NRD*AW-1:0] rd_addr_i,
  output logic [NRD*DW-1:0] rd_data_o
);

  localparam int NLK = NWR - 1;

  logic          rst_n;
  logic [AW-1:0] wa     [NWR];
  logic [DW-1:0] wd     [NWR];
  logic [AW-1:0] ra     [NRD];
  logic [AW-1:0] lk_a   [NWR][NLK];
  logic [DW-1:0] lk_out [NWR][NLK];
  logic [DW-1:0] peer   [NWR][NLK];
  logic [DW-1:0] grp_rd [NWR][NRD];
  logic [DW-1:0] rd_x   [NRD];

  xmp_rst_sync #(.STAGES(2)) u_rst (
    .clk    (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n)
  );

  for (genvar p = 0; p < NWR; p++) begin : g_wsplit
    assign wa[p] = wr_addr_i[p*AW +: AW];
    assign wd[p] = wr_data_i[p*DW +: DW];
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rsplit
    assign ra[r] = rd_addr_i[r*AW +: AW];
  end

  for (genvar g = 0; g < NWR; g++) begin : g_grp
    for (genvar s = 0; s < NLK; s++) begin : g_slot
      localparam int OTHER = xmp_pkg::port_of(g, s);
      // slot s of group g looks up on behalf of write port OTHER
      assign lk_a[g][s] = wa[OTHER];
      // group g's encoding needs group OTHER's lookup at g's address
      assign peer[g][s] = lk_out[OTHER][xmp_pkg::slot_of(OTHER, g)];
    end

    xmp_group #(
      .NWR   (NWR),
      .NRD   (NRD),
      .DW    (DW),
      .DEPTH (DEPTH)
    ) u_group (
      .clk       (clk_i),
      .rst_n     (rst_n),
      .wr_en     (wr_en_i[g]),
      .wr_addr   (wa[g]),
      .wr_data   (wd[g]),
      .lk_addr   (lk_a[g]),
      .peer_data (peer[g]),
      .rd_addr   (ra),
      .lk_data   (lk_out[g]),
      .rd_data   (grp_rd[g])
    );
  end

  always_comb begin
    for (int r = 0; r < NRD; r++) begin
      rd_x[r] = '0;
      for (int g = 0; g < NWR; g++) begin
        rd_x[r] = rd_x[r] ^ grp_rd[g][r];
      end
    end
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rjoin
    assign rd_data_o[r*DW +: DW] = rd_x[r];
  end

  for (genvar i = 0; i < NWR; i++) begin : g_chk_i
    for (genvar j = i + 1; j < NWR; j++) begin : g_chk_j
      AST_WR_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_n)
        !(wr_en_i[i] && wr_en_i[j] && (wa[i] == wa[j])))
        else $error("two write ports hit one address");  // R7
    end
  end

  for (genvar p = 0; p < NWR; p++) begin : g_chk_p
    for (genvar r = 0; r < NRD; r++) begin : g_chk_r
      AST_RD_AFTER_WR: assert property (@(posedge clk_i) disable iff (!rst_n)
        ($past(wr_en_i[p], 2) && ($past(wa[p], 2) == $past(ra[r])))
          |-> (rd_data_o[r*DW +: DW] == $past(wd[p], 2)))
        else $error("read after write returned wrong data");  // R2
    end
  end

endmodule

// File: tb/xmp_xor_mem_test.sv
module xmp_xor_mem_test;

  localparam int NWR = 2, NRD = 2, DW = 16, DEPTH = 16, AW = 4;

  typedef struct packed {
    logic [3:0]    req;
    logic [1:0]    we;
    logic [AW-1:0] wa0;
    logic [DW-1:0] wd0;
    logic [AW-1:0] wa1;
    logic [DW-1:0] wd1;
    logic [AW-1:0] ra0;
    logic [AW-1:0] ra1;
    logic [DW-1:0] e0;
    logic [DW-1:0] e1;
  } vec_t;

  localparam int NVEC = 13;
  localparam vec_t VEC [NVEC] = '{
    '{4'd1, 2'b00, 4'h0, 16'h0000, 4'h0, 16'h0000, 4'h3, 4'h5, 16'h0000, 16'h0000}, // R1
    '{4'd4, 2'b11, 4'h3, 16'h1111, 4'h5, 16'h2222, 4'h3, 4'h5, 16'h0000, 16'h0000}, // R4
    '{4'd2, 2'b00, 4'h0, 16'h0000, 4'h0, 16'h0000, 4'h3, 4'h5, 16'h1111, 16'h2222}, // R2
    '{4'd4, 2'b01, 4'h5, 16'hAAAA, 4'h5, 16'hFFFF, 4'h5, 4'h3, 16'h2222, 16'h1111}, // R4
    '{4'd6, 2'b10, 4'h5, 16'hDEAD, 4'h5, 16'hBBBB, 4'h5, 4'h5, 16'hAAAA, 16'hAAAA}, // R6
    '{4'd5, 2'b01, 4'h5, 16'hCCCC, 4'h0, 16'h0000, 4'h5, 4'h3, 16'hBBBB, 16'h1111}, // R5
    '{4'd8, 2'b00, 4'h5, 16'h0000, 4'h3, 16'h0000, 4'h5, 4'h5, 16'hCCCC, 16'hCCCC}, // R8
    '{4'd4, 2'b11, 4'h0, 16'h0001, 4'hF, 16'h8000, 4'h0, 4'hF, 16'h0000, 16'h0000}, // R4
    '{4'd7, 2'b00, 4'h0, 16'h0000, 4'h0, 16'h0000, 4'hF, 4'h0, 16'h8000, 16'h0001}, // R7
    '{4'd6, 2'b11, 4'hF, 16'h1234, 4'h0, 16'h5678, 4'h5, 4'h3, 16'hCCCC, 16'h1111}, // R6
    '{4'd7, 2'b00, 4'h0, 16'h0000, 4'h0, 16'h0000, 4'h0, 4'hF, 16'h5678, 16'h1234}, // R7
    '{4'd4, 2'b11, 4'h7, 16'hFFFF, 4'h8, 16'hFFFF, 4'h7, 4'h8, 16'h0000, 16'h0000}, // R4
    '{4'd7, 2'b00, 4'h0, 16'h0000, 4'h0, 16'h0000, 4'h7, 4'h8, 16'hFFFF, 16'hFFFF}  // R7
  };

  logic                clk;
  logic                rst_n;
  logic [NWR-1:0]      we;
  logic [NWR*AW-1:0]   wa;
  logic [NWR*DW-1:0]   wd;
  logic [NRD*AW-1:0]   ra;
  logic [NRD*DW-1:0]   rd;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp0, exp1;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  xmp_xor_mem #(.NWR(NWR), .NRD(NRD), .DW(DW), .DEPTH(DEPTH)) uut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .wr_en_i   (we),
    .wr_addr_i (wa),
    .wr_data_i (wd),
    .rd_addr_i (ra),
    .rd_data_o (rd)
  );

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // drive one cycle; expected reads come from the model before this cycle's writes
  task automatic drive(input logic [1:0] e, input logic [AW-1:0] a0, input logic [DW-1:0] d0,
                       input logic [AW-1:0] a1, input logic [DW-1:0] d1,
                       input logic [AW-1:0] r0, input logic [AW-1:0] r1);
    we = e;
    wa = {a1, a0};
    wd = {d1, d0};
    ra = {r1, r0};
    exp0 = model[r0];
    exp1 = model[r1];
    if (e[0]) model[a0] = d0;
    if (e[1]) model[a1] = d1;
  endtask

  task automatic clear_model();
    for (int i = 0; i < DEPTH; i++) model[i] = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    we = '0; wa = '0; wd = '0; ra = '0;
    clear_model();
    repeat (3) @(negedge clk);
    check("R1 during reset port0", rd[DW-1:0], '0);
    check("R1 during reset port1", rd[2*DW-1:DW], '0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // directed vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i].we, VEC[i].wa0, VEC[i].wd0, VEC[i].wa1, VEC[i].wd1, VEC[i].ra0, VEC[i].ra1);
      @(negedge clk);
      check($sformatf("R%0d vec%0d port0", VEC[i].req, i), rd[DW-1:0], VEC[i].e0);
      check($sformatf("R%0d vec%0d port1", VEC[i].req, i), rd[2*DW-1:DW], VEC[i].e1);
    end

    // R3: held address, no writes, output steady
    for (int k = 0; k < 4; k++) begin
      drive(2'b00, 4'h7, 16'h0BAD, 4'h8, 16'h0BAD, 4'h7, 4'h8);
      @(negedge clk);
      check("R3 hold port0", rd[DW-1:0], 16'hFFFF);
      check("R3 hold port1", rd[2*DW-1:DW], 16'hFFFF);
    end

    // random traffic, narrow address range half the time, distinct write addresses
    for (int n = 0; n < 3000; n++) begin
      logic [1:0]    e;
      logic [AW-1:0] a0, a1, r0, r1;
      bit narrow;
      narrow = n[0];
      e  = 2'($urandom_range(0, 3));
      a0 = narrow ? 4'($urandom_range(0, 3)) : 4'($urandom_range(0, 15));
      a1 = narrow ? 4'($urandom_range(0, 3)) : 4'($urandom_range(0, 15));
      r0 = narrow ? 4'($urandom_range(0, 3)) : 4'($urandom_range(0, 15));
      r1 = narrow ? 4'($urandom_range(0, 3)) : 4'($urandom_range(0, 15));
      if (a1 == a0) a1 = a0 + 4'd1;
      drive(e, a0, 16'($urandom), a1, 16'($urandom), r0, r1);
      @(negedge clk);
      check("R5 random port0", rd[DW-1:0], exp0);
      check("R6 random port1", rd[2*DW-1:DW], exp1);
    end

    // R1: reset in mid-run clears everything
    drive(2'b00, 4'h0, 16'h0, 4'h0, 16'h0, 4'h0, 4'h0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    clear_model();
    repeat (3) @(negedge clk);
    for (int a = 0; a < DEPTH; a++) begin
      drive(2'b00, 4'h0, 16'h0, 4'h0, 16'h0, 4'(a), 4'(DEPTH - 1 - a));
      @(negedge clk);
      check("R1 after mid reset port0", rd[DW-1:0], '0);
      check("R1 after mid reset port1", rd[2*DW-1:DW], '0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule